// File: doc/BRIEF.md
# Command/Response Byte Mailbox

This block is a byte-serial mailbox between a host register port and a command-processing backend. The host writes a command into a command buffer one to four bytes at a time through a data window, then writes a start bit. The block hands the filled buffer to the backend with a one-cycle start pulse and the byte count. The backend reads the command through its own read port, writes its answer into a response buffer, and pulses done. The host then drains the answer through the same data window.

A five-state sequencer (idle, ready, reception, execution, completion) sets the protocol flags in a 32-bit status word. The status word also carries a burst count: the response bytes left while an answer is pending, or the free command space otherwise. The message length is taken from a big-endian 32-bit field at byte offsets 2 to 5 of each stream. The block emits one-cycle event pulses for an interrupt unit.

Top module: `cmdrsp_mbox`

## Requirements
- R1: After reset the state is idle. A 4-byte status read (offset 0x18) returns only the family code in bits 27:26 and the free space (DEPTH) in burst bits 23:8. All event, start and cancel outputs are low.
- R2: Writing the command-ready bit (bit 6) alone in idle moves to ready, makes the status flags command-ready only, and pulses ev_cmd_ready.
- R3: A data write (offset 0x24 or 0x80..0xBC) in ready enters reception and sets expect (bit 3) and valid (bit 7). Data writes in idle, execution or completion change nothing. Bytes are taken least-significant first, and an access is truncated at its 32-bit word boundary.
- R4: Once more than 5 command bytes are held, the big-endian length at bytes 2..5 is compared with the byte count. While bytes are missing the flags are expect plus valid; when complete they are valid only. ev_sts_valid pulses only if valid was clear before the check.
- R5: When the command buffer is full, a further byte is discarded and the flags become valid only.
- R6: Writing go (bit 5) alone in reception with expect clear enters execution and pulses cmd_start with cmd_len equal to the bytes held; the backend reads the bytes back in order. Go in any other case, and any write setting more than one of bits 6, 5 and 1, is ignored.
- R7: be_done in execution enters completion, makes the flags valid plus data-available (bit 4), and pulses ev_data_avail and ev_sts_valid together.
- R8: Each data-window read byte in completion with data available returns the next response byte. When the count reaches the response length the flags become valid only and ev_sts_valid pulses. Any other data read byte returns 0xFF.
- R9: The burst count is response length minus bytes read while data is available, otherwise DEPTH minus bytes held. A 1-byte status access clamps it to 0xFF.
- R10: Writing retry (bit 1) alone in completion rewinds the read pointer and restores valid plus data-available.
- R11: Command-ready in ready clears the held byte count. In completion it clears both pointers, moves to ready, sets command-ready (pulsing ev_cmd_ready if it was clear) and clears data-available.
- R12: Command-ready in reception aborts at once to ready with command-ready and ev_cmd_ready. In execution it pulses be_cancel, and the following be_done lands in ready with command-ready and ev_cmd_ready instead of completion.
- R13: With host_owner low, status and data reads return 0xFFFFFFFF and writes have no effect.
- R14: Self-test done (bit 2) is set when be_done arrives with be_selftest high. It survives every later flag update until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_owner | input | 1 | The accessing locality is the active one |
| host_addr | input | 12 | Byte address within the register window |
| host_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| host_wdata | input | 32 | Write data, right-aligned |
| host_rdata | output | 32 | Read data, valid in the cycle of host_req |
| cmd_start | output | 1 | Pulse: command handed to the backend |
| cmd_len | output | PW (11) | Command bytes held |
| be_cancel | output | 1 | Pulse: cancel the running command |
| be_rd_addr | input | AW (10) | Backend command read address |
| be_rd_data | output | 8 | Command byte at be_rd_addr |
| be_wr_en | input | 1 | Backend response byte write |
| be_wr_addr | input | AW (10) | Response byte address |
| be_wr_data | input | 8 | Response byte |
| be_done | input | 1 | Pulse: response complete |
| be_selftest | input | 1 | Qualifies be_done: self-test finished |
| ev_cmd_ready | output | 1 | Event: command-ready raised |
| ev_sts_valid | output | 1 | Event: status valid raised |
| ev_data_avail | output | 1 | Event: response available |

## Verification
The command path is driven with mixed access widths: a full word, a word access truncated to one byte at the last lane, and a 2-byte access at an odd lane. A mismatch in lane order or truncation then shows up as a wrong length decode or wrong bytes seen by the backend. The response path is drained with 4-byte, truncated and 1-byte reads, including a read that crosses the end of the answer mid-access, so the switch to 0xFF filler is seen inside one word. A command that overruns the buffer separates the full-buffer rule from the length rule. Abort is exercised in both reception and execution to tell the immediate path from the deferred one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READY = 3'd1,
        ST_RECV  = 3'd2,
        ST_EXEC  = 3'd3,
        ST_CMPL  = 3'd4
    } mbx_state_e;

    // Protocol flags that a status update replaces as a group.
    typedef struct packed {
        logic valid;
        logic cmd_ready;
        logic data_avail;
        logic expect_more;
    } mbx_flags_t;

    localparam int BIT_VALID = 7;
    localparam int BIT_CRDY  = 6;
    localparam int BIT_GO    = 5;
    localparam int BIT_DAV   = 4;
    localparam int BIT_EXP   = 3;
    localparam int BIT_STD   = 2;
    localparam int BIT_RETRY = 1;

    localparam logic [11:0] OFF_STATUS = 12'h018;
    localparam logic [11:0] OFF_DATA   = 12'h024;
    localparam logic [11:0] OFF_WIN_LO = 12'h080;
    localparam logic [11:0] OFF_WIN_HI = 12'h0BC;

    function automatic mbx_flags_t mk_flags(input logic v, input logic c,
                                            input logic d, input logic e);
        mbx_flags_t f;
        f.valid       = v;
        f.cmd_ready   = c;
        f.data_avail  = d;
        f.expect_more = e;
        return f;
    endfunction

    // Bytes actually moved: requested size, truncated at the word boundary.
    function automatic logic [2:0] acc_bytes(input logic [1:0] size, input logic [1:0] lo);
        logic [2:0] want;
        logic [2:0] room;
        want = (size == 2'd0) ? 3'd1 : ((size == 2'd1) ? 3'd2 : 3'd4);
        room = 3'd4 - {1'b0, lo};
        return (want < room) ? want : room;
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] size);
        return (size == 2'd0) ? 32'h0000_00FF :
               ((size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF);
    endfunction

    function automatic logic is_data_off(input logic [11:0] off);
        return (off == OFF_DATA) || (off >= OFF_WIN_LO && off <= OFF_WIN_HI);
    endfunction

endpackage

// File: rtl/mbx_bytebuf.sv
module mbx_bytebuf #(
    parameter int DEPTH = 1024,
    parameter int WL    = 4,
    parameter int RL    = 1,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic [WL-1:0]          we,
    input  logic [WL-1:0][AW-1:0]  waddr,
    input  logic [WL-1:0][7:0]     wdata,
    input  logic [RL-1:0][AW-1:0]  raddr,
    output logic [RL-1:0][7:0]     rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WL; i++) begin
            if (we[i]) mem[waddr[i]] <= wdata[i];
        end
    end

    for (genvar g = 0; g < RL; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end
endmodule

// File: rtl/mbx_sts_view.sv
module mbx_sts_view
    import mbx_pkg::*;
#(
    parameter int         DEPTH  = 1024,
    parameter int         PW     = $clog2(DEPTH) + 1,
    parameter logic [1:0] FAMILY = 2'b01
) (
    input  mbx_flags_t    flags,
    input  logic          selftest,
    input  logic [31:0]   rsp_len,
    input  logic [PW-1:0] rd_ptr,
    input  logic [PW-1:0] wr_ptr,
    input  logic          one_byte,
    output logic [31:0]   word
);
    logic [31:0] raw;
    logic [15:0] burst;

    always_comb begin
        if (flags.data_avail) raw = rsp_len - 32'(rd_ptr);
        else                  raw = 32'(DEPTH) - 32'(wr_ptr);
        if (one_byte && raw > 32'd255) burst = 16'h00FF;
        else                           burst = raw[15:0];
        word = '0;
        word[27:26]     = FAMILY;
        word[23:8]      = burst;
        word[BIT_VALID] = flags.valid;
        word[BIT_CRDY]  = flags.cmd_ready;
        word[BIT_DAV]   = flags.data_avail;
        word[BIT_EXP]   = flags.expect_more;
        word[BIT_STD]   = selftest;
    end
endmodule

// File: rtl/cmdrsp_mbox.sv
module cmdrsp_mbox
    import mbx_pkg::*;
#(
    parameter int         DEPTH  = 1024,
    parameter logic [1:0] FAMILY = 2'b01,
    parameter int         AW     = $clog2(DEPTH),
    parameter int         PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  logic          host_we,
    input  logic          host_owner,
    input  logic [11:0]   host_addr,
    input  logic [1:0]    host_size,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    output logic          cmd_start,
    output logic [PW-1:0] cmd_len,
    output logic          be_cancel,
    input  logic [AW-1:0] be_rd_addr,
    output logic [7:0]    be_rd_data,
    input  logic          be_wr_en,
    input  logic [AW-1:0] be_wr_addr,
    input  logic [7:0]    be_wr_data,
    input  logic          be_done,
    input  logic          be_selftest,
    output logic          ev_cmd_ready,
    output logic          ev_sts_valid,
    output logic          ev_data_avail
);
    localparam int LANES = 4;

    mbx_state_e    st_q, st_n;
    mbx_flags_t    fl_q, fl_n;
    logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
    logic [31:0]   wlen_q, wlen_n, rlen_q;
    logic          abort_q, abort_n, std_q, std_n;

    logic [11:0]   off;
    logic [1:0]    lo;
    logic [2:0]    nb;
    logic          acc_data, acc_sts, own_rd, own_wr;
    logic [31:0]   sts_word, wr_bits;
    logic [2:0]    ctl;

    logic [LANES-1:0]          cw_we;
    logic [LANES-1:0][AW-1:0]  cw_addr;
    logic [LANES-1:0][7:0]     cw_data;
    logic [LANES-1:0][AW-1:0]  rr_addr;
    logic [LANES-1:0][7:0]     rr_data;
    logic [0:0][AW-1:0]        br_addr;
    logic [0:0][7:0]           br_data;

    assign off      = {host_addr[11:2], 2'b00};
    assign lo       = host_addr[1:0];
    assign nb       = acc_bytes(host_size, lo);
    assign acc_data = is_data_off(off);
    assign acc_sts  = (off == OFF_STATUS);
    assign own_rd   = host_req && !host_we && host_owner;
    assign own_wr   = host_req && host_we && host_owner;
    assign wr_bits  = (host_wdata & size_mask(host_size)) << {lo, 3'b000};
    assign ctl      = {wr_bits[BIT_CRDY], wr_bits[BIT_GO], wr_bits[BIT_RETRY]};

    assign cmd_len    = wp_q;
    assign br_addr[0] = be_rd_addr;
    assign be_rd_data = br_data[0];

    for (genvar g = 0; g < LANES; g++) begin : g_rlane
        assign rr_addr[g] = rp_q[AW-1:0] + AW'(g);
    end

    // Command buffer: host writes up to four lanes, backend reads one.
    mbx_bytebuf #(.DEPTH(DEPTH), .WL(LANES), .RL(1), .AW(AW)) u_cmd_buf (
        .clk(clk), .we(cw_we), .waddr(cw_addr), .wdata(cw_data),
        .raddr(br_addr), .rdata(br_data)
    );

    // Response buffer: backend writes one lane, host reads up to four.
    mbx_bytebuf #(.DEPTH(DEPTH), .WL(1), .RL(LANES), .AW(AW)) u_rsp_buf (
        .clk(clk), .we(be_wr_en), .waddr(be_wr_addr), .wdata(be_wr_data),
        .raddr(rr_addr), .rdata(rr_data)
    );

    mbx_sts_view #(.DEPTH(DEPTH), .PW(PW), .FAMILY(FAMILY)) u_sts (
        .flags(fl_q), .selftest(std_q), .rsp_len(rlen_q), .rd_ptr(rp_q),
        .wr_ptr(wp_q), .one_byte(host_size == 2'd0), .word(sts_word)
    );

    always_comb begin
        logic [PW-1:0] w;
        logic [PW-1:0] r;
        logic [7:0]    b;
        logic          need;

        st_n = st_q; fl_n = fl_q; wp_n = wp_q; rp_n = rp_q;
        wlen_n = wlen_q; abort_n = abort_q; std_n = std_q;
        host_rdata = 32'hFFFF_FFFF;
        cmd_start = 1'b0; be_cancel = 1'b0;
        ev_cmd_ready = 1'b0; ev_sts_valid = 1'b0; ev_data_avail = 1'b0;
        cw_we = '0; cw_addr = '0; cw_data = '0;
        w = wp_q; r = rp_q; b = 8'hFF; need = 1'b0;

        // Host reads
        if (own_rd && acc_sts) begin
            host_rdata = sts_word >> {lo, 3'b000};
        end else if (own_rd && acc_data) begin
            host_rdata = '0;
            for (int k = 0; k < LANES; k++) begin
                if (3'(k) < nb) begin
                    b = 8'hFF;
                    if (st_q == ST_CMPL && fl_n.data_avail) begin
                        b = rr_data[k];
                        r = r + PW'(1);
                        if (32'(r) >= rlen_q) begin
                            fl_n = mk_flags(1'b1, 1'b0, 1'b0, 1'b0);
                            ev_sts_valid = 1'b1;
                        end
                    end
                    host_rdata[8*k +: 8] = b;
                end
            end
            rp_n = r;
        end

        // Host status writes: exactly one control bit acts
        if (own_wr && acc_sts) begin
            case (ctl)
                3'b100: begin
                    case (st_q)
                        ST_IDLE: begin
                            st_n = ST_READY;
                            fl_n = mk_flags(1'b0, 1'b1, 1'b0, 1'b0);
                            ev_cmd_ready = 1'b1;
                        end
                        ST_READY: begin
                            wp_n = '0; rp_n = '0;
                        end
                        ST_RECV: begin
                            wp_n = '0; rp_n = '0;
                            st_n = ST_READY;
                            fl_n = mk_flags(1'b0, 1'b1, 1'b0, 1'b0);
                            ev_cmd_ready = 1'b1;
                        end
                        ST_EXEC: begin
                            be_cancel = 1'b1;
                            abort_n = 1'b1;
                        end
                        default: begin
                            wp_n = '0; rp_n = '0;
                            st_n = ST_READY;
                            if (!fl_q.cmd_ready) begin
                                fl_n = mk_flags(1'b0, 1'b1, 1'b0, 1'b0);
                                ev_cmd_ready = 1'b1;
                            end
                            fl_n.data_avail = 1'b0;
                        end
                    endcase
                end
                3'b010: begin
                    if (st_q == ST_RECV && !fl_q.expect_more) begin
                        st_n = ST_EXEC;
                        cmd_start = 1'b1;
                    end
                end
                3'b001: begin
                    if (st_q == ST_CMPL) begin
                        rp_n = '0;
                        fl_n = mk_flags(1'b1, 1'b0, 1'b1, 1'b0);
                    end
                end
                default: ;
            endcase
        end

        // Host data writes
        if (own_wr && acc_data && (st_q == ST_READY || st_q == ST_RECV)) begin
            if (st_q == ST_READY) begin
                st_n = ST_RECV;
                fl_n = mk_flags(1'b1, 1'b0, 1'b0, 1'b1);
            end
            for (int k = 0; k < LANES; k++) begin
                if (3'(k) < nb && fl_n.expect_more) begin
                    if (w < PW'(DEPTH)) begin
                        cw_we[k]   = 1'b1;
                        cw_addr[k] = w[AW-1:0];
                        cw_data[k] = host_wdata[8*k +: 8];
                        if (w >= PW'(2) && w <= PW'(5))
                            wlen_n[8*(5 - int'(w)) +: 8] = host_wdata[8*k +: 8];
                        w = w + PW'(1);
                    end else begin
                        fl_n = mk_flags(1'b1, 1'b0, 1'b0, 1'b0);
                    end
                end
            end
            wp_n = w;
            if (w > PW'(5) && fl_n.expect_more) begin
                need = !fl_n.valid;
                if (wlen_n > 32'(w)) fl_n = mk_flags(1'b1, 1'b0, 1'b0, 1'b1);
                else                 fl_n = mk_flags(1'b1, 1'b0, 1'b0, 1'b0);
                if (need) ev_sts_valid = 1'b1;
            end
        end

        // Backend completion
        if (be_done && st_q == ST_EXEC) begin
            std_n = std_q | be_selftest;
            wp_n = '0; rp_n = '0;
            if (abort_n) begin
                st_n = ST_READY;
                fl_n = mk_flags(1'b0, 1'b1, 1'b0, 1'b0);
                ev_cmd_ready = 1'b1;
                abort_n = 1'b0;
            end else begin
                st_n = ST_CMPL;
                fl_n = mk_flags(1'b1, 1'b0, 1'b1, 1'b0);
                ev_data_avail = 1'b1;
                ev_sts_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE; fl_q <= '0; wp_q <= '0; rp_q <= '0;
            wlen_q <= '0; rlen_q <= '0; abort_q <= 1'b0; std_q <= 1'b0;
        end else begin
            st_q <= st_n; fl_q <= fl_n; wp_q <= wp_n; rp_q <= rp_n;
            wlen_q <= wlen_n; abort_q <= abort_n; std_q <= std_n;
            if (be_wr_en && be_wr_addr >= AW'(2) && be_wr_addr <= AW'(5))
                rlen_q[8*(5 - int'(be_wr_addr)) +: 8] <= be_wr_data;
        end
    end

    // R3
    drop_write_chk: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_we && host_owner && acc_data && !be_done &&
         (st_q == ST_IDLE || st_q == ST_EXEC || st_q == ST_CMPL)) |=> $stable(wp_q));
    // R6
    go_exec_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> (st_q == ST_EXEC));
    // R7
    dav_event_chk: assert property (@(posedge clk) disable iff (rst)
        ev_data_avail |=> (st_q == ST_CMPL && fl_q.data_avail && fl_q.valid));
    // R4
    exp_dav_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fl_q.expect_more && fl_q.data_avail));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        wp_q <= PW'(DEPTH));
    // R14
    selftest_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !$fell(std_q));
    // R13
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (host_req && !host_owner && !be_done) |=> ($stable(st_q) && $stable(fl_q)));
endmodule

// File: tb/test_cmdrsp_mbox.sv
module test_cmdrsp_mbox;
    localparam int DEPTH = 1024;
    localparam int AW = 10;
    localparam int PW = 11;

    logic clk = 1'b0, rst = 1'b1;
    logic host_req = 0, host_we = 0, host_owner = 1;
    logic [11:0] host_addr = '0;
    logic [1:0] host_size = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic cmd_start, be_cancel, ev_cmd_ready, ev_sts_valid, ev_data_avail;
    logic [PW-1:0] cmd_len;
    logic [AW-1:0] be_rd_addr = '0, be_wr_addr = '0;
    logic [7:0] be_rd_data, be_wr_data = '0;
    logic be_wr_en = 0, be_done = 0, be_selftest = 0;

    cmdrsp_mbox i_cmdrsp_mbox (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit done_flag = 0;

    // reference model
    int m_st = 0, m_wp = 0, m_rp = 0;
    bit m_valid = 0, m_crdy = 0, m_dav = 0, m_exp = 0, m_std = 0, m_abort = 0;
    logic [7:0] m_cmd [DEPTH];
    logic [7:0] m_rsp [DEPTH];
    bit e_cr, e_sv, e_dav, e_start, e_cancel;

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic setfl(bit v, bit c, bit d, bit e);
        m_valid = v; m_crdy = c; m_dav = d; m_exp = e;
    endtask

    function automatic int rsp_len();
        return {m_rsp[2], m_rsp[3], m_rsp[4], m_rsp[5]};
    endfunction

    function automatic int cmd_field();
        return {m_cmd[2], m_cmd[3], m_cmd[4], m_cmd[5]};
    endfunction

    function automatic logic [31:0] sts_word(bit one);
        int bc;
        logic [31:0] v;
        bc = m_dav ? rsp_len() - m_rp : DEPTH - m_wp;
        if (one && bc > 255) bc = 255;
        v = 32'h0400_0000 | (32'(bc & 16'hFFFF) << 8);
        v = v | {24'd0, m_valid, m_crdy, 1'b0, m_dav, m_exp, m_std, 2'b00};
        return v;
    endfunction

    task automatic clear_in();
        host_req = 0; host_we = 0; host_owner = 1; be_wr_en = 0; be_done = 0; be_selftest = 0;
        e_cr = 0; e_sv = 0; e_dav = 0; e_start = 0; e_cancel = 0;
    endtask

    task automatic finish_step(string req);
        #1;
        check(req, "events", {ev_cmd_ready, ev_sts_valid, ev_data_avail, cmd_start, be_cancel},
              {e_cr, e_sv, e_dav, e_start, e_cancel});
        @(posedge clk);
    endtask

    task automatic host(bit we, bit own, int addr, int size, logic [31:0] wd, string req);
        int off, lo, nb, c;
        logic [31:0] exp_rd, bits;
        logic [7:0] b;
        bit need, pre_exp;
        @(negedge clk);
        clear_in();
        host_req = 1; host_we = we; host_owner = own; host_addr = 12'(addr);
        host_size = 2'(size); host_wdata = wd;
        off = addr & 'hFFC; lo = addr & 3;
        nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        if (nb > 4 - lo) nb = 4 - lo;
        exp_rd = 32'hFFFF_FFFF;
        if (own && off == 'h18 && !we) exp_rd = sts_word(size == 0) >> (lo * 8);
        if (own && (off == 'h24 || (off >= 'h80 && off <= 'hBC)) && !we) begin
            exp_rd = 0;
            for (int k = 0; k < nb; k++) begin
                b = 8'hFF;
                if (m_st == 4 && m_dav) begin
                    b = m_rsp[m_rp % DEPTH]; m_rp++;
                    if (m_rp >= rsp_len()) begin setfl(1, 0, 0, 0); e_sv = 1; end
                end
                exp_rd[8*k +: 8] = b;
            end
        end
        if (own && off == 'h18 && we) begin
            bits = (size == 0) ? (wd & 32'hFF) : (size == 1) ? (wd & 32'hFFFF) : wd;
            bits = bits << (lo * 8);
            c = int'(bits & 32'h62);
            if (c == 'h40) begin
                if (m_st == 0) begin m_st = 1; setfl(0, 1, 0, 0); e_cr = 1; end
                else if (m_st == 1) begin m_wp = 0; m_rp = 0; end
                else if (m_st == 2) begin m_wp = 0; m_rp = 0; m_st = 1; setfl(0, 1, 0, 0); e_cr = 1; end
                else if (m_st == 3) begin e_cancel = 1; m_abort = 1; end
                else begin
                    m_wp = 0; m_rp = 0; m_st = 1;
                    if (!m_crdy) begin setfl(0, 1, 0, 0); e_cr = 1; end
                    m_dav = 0;
                end
            end else if (c == 'h20) begin
                if (m_st == 2 && !m_exp) begin m_st = 3; e_start = 1; end
            end else if (c == 'h02) begin
                if (m_st == 4) begin m_rp = 0; setfl(1, 0, 1, 0); end
            end
        end
        pre_exp = 0;
        if (own && (off == 'h24 || (off >= 'h80 && off <= 'hBC)) && we && (m_st == 1 || m_st == 2)) begin
            if (m_st == 1) begin m_st = 2; setfl(1, 0, 0, 1); end
            for (int k = 0; k < nb; k++) begin
                if (!m_exp) break;
                if (m_wp < DEPTH) begin m_cmd[m_wp] = wd[8*k +: 8]; m_wp++; end
                else begin setfl(1, 0, 0, 0); break; end
            end
            if (m_wp > 5 && m_exp) begin
                need = !m_valid;
                if (cmd_field() > m_wp) setfl(1, 0, 0, 1); else setfl(1, 0, 0, 0);
                if (need) e_sv = 1;
            end
        end
        #1;
        if (!we) check(req, "rdata", host_rdata, exp_rd);
        if (e_start) check(req, "cmd_len", cmd_len, m_wp);
        #0;
        finish_step(req);
    endtask

    task automatic be_put(int a, logic [7:0] d, string req);
        @(negedge clk);
        clear_in();
        be_wr_en = 1; be_wr_addr = AW'(a); be_wr_data = d;
        m_rsp[a] = d;
        finish_step(req);
    endtask

    task automatic be_finish(bit sel, string req);
        @(negedge clk);
        clear_in();
        be_done = 1; be_selftest = sel;
        if (m_st == 3) begin
            m_std = m_std | sel; m_wp = 0; m_rp = 0;
            if (m_abort) begin m_st = 1; setfl(0, 1, 0, 0); e_cr = 1; m_abort = 0; end
            else begin m_st = 4; setfl(1, 0, 1, 0); e_dav = 1; e_sv = 1; end
        end
        finish_step(req);
    endtask

    task automatic be_peek(int i, string req);
        @(negedge clk);
        clear_in();
        be_rd_addr = AW'(i);
        #1;
        check(req, "cmd byte", be_rd_data, m_cmd[i]);
        @(posedge clk);
    endtask

    task automatic rd_sts(string req);
        host(0, 1, 'h18, 2, 0, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        clear_in();
        // R1 reset state
        #1;
        check("R1", "idle outputs", {ev_cmd_ready, ev_sts_valid, ev_data_avail, cmd_start, be_cancel}, 0);
        check("R1", "status", sts_word(0), 32'h0404_0000);
        @(posedge clk);
        rd_sts("R1");
        host(0, 1, 'h19, 0, 0, "R9");          // byte read clamps burst
        host(1, 1, 'h24, 2, 32'h1234_5678, "R3"); // dropped in idle
        rd_sts("R3");
        // R13 foreign locality
        host(0, 0, 'h18, 2, 0, "R13");
        host(1, 0, 'h18, 2, 32'h40, "R13");
        host(0, 0, 'h24, 2, 0, "R13");
        rd_sts("R13");
        // R2
        host(1, 1, 'h18, 2, 32'h40, "R2");
        rd_sts("R2");
        // R3 R4 command with mixed widths
        host(1, 1, 'h24, 2, 32'h0000_0180, "R3");
        rd_sts("R3");
        host(1, 1, 'h83, 2, 32'hEEEE_EE00, "R3");
        host(1, 1, 'h86, 1, 32'h0000_110A, "R4");
        rd_sts("R4");
        host(1, 1, 'h18, 2, 32'h20, "R6");     // go while expect: ignored
        host(0, 1, 'h24, 2, 0, "R8");          // read in reception: 0xFF
        host(1, 1, 'h24, 2, 32'hAA44_3322, "R4");
        rd_sts("R4");
        host(1, 1, 'h18, 2, 32'h60, "R6");     // two control bits: ignored
        host(1, 1, 'h18, 0, 32'h20, "R6");     // go
        for (int i = 0; i < 11; i++) be_peek(i, "R6");
        host(1, 1, 'h24, 2, 32'h0101_0101, "R3"); // dropped in execution
        rd_sts("R3");
        // R7 response
        be_put(0, 8'hC4, "R7"); be_put(1, 8'h00, "R7");
        be_put(2, 8'h00, "R7"); be_put(3, 8'h00, "R7");
        be_put(4, 8'h00, "R7"); be_put(5, 8'h0C, "R7");
        for (int i = 6; i < 12; i++) be_put(i, 8'(i * 7), "R7");
        be_finish(1, "R7");
        rd_sts("R9");
        host(1, 1, 'h24, 2, 32'h5555_5555, "R3"); // dropped in completion
        host(0, 1, 'h24, 2, 0, "R8");
        host(0, 1, 'h82, 2, 0, "R8");
        host(0, 1, 'h24, 0, 0, "R8");
        rd_sts("R9");
        host(0, 1, 'h24, 2, 0, "R8");
        host(0, 1, 'h24, 1, 0, "R8");          // crosses end of answer
        host(0, 1, 'h24, 2, 0, "R8");
        rd_sts("R8");
        host(1, 1, 'h18, 2, 32'h22, "R10");    // two bits: ignored
        host(0, 1, 'h24, 0, 0, "R10");
        host(1, 1, 'h18, 2, 32'h02, "R10");
        rd_sts("R10");
        host(0, 1, 'h24, 0, 0, "R10");
        // R11 / R14
        host(1, 1, 'h18, 2, 32'h40, "R11");
        rd_sts("R14");
        host(0, 1, 'h24, 2, 0, "R11");
        // R12 abort in reception
        host(1, 1, 'h24, 1, 32'h0180, "R12");
        host(1, 1, 'h18, 2, 32'h40, "R12");
        rd_sts("R12");
        // R11 ready clears pointer
        host(1, 1, 'h24, 0, 32'h80, "R11");
        host(1, 1, 'h18, 2, 32'h40, "R12");
        host(1, 1, 'h18, 2, 32'h40, "R11");
        rd_sts("R11");
        // R12 abort in execution
        host(1, 1, 'h24, 2, 32'h0000_0180, "R12");
        host(1, 1, 'h24, 1, 32'h0600, "R12");
        rd_sts("R12");
        host(1, 1, 'h18, 2, 32'h20, "R12");
        host(1, 1, 'h18, 2, 32'h40, "R12");
        be_finish(0, "R12");
        rd_sts("R14");
        // R5 overfill
        host(1, 1, 'h24, 2, 32'h0000_0180, "R5");
        host(1, 1, 'h24, 2, 32'h0000_0020, "R5");
        for (int i = 2; i < DEPTH / 4; i++) host(1, 1, 'h80 + 4 * (i % 16), 2, 32'(i), "R5");
        rd_sts("R5");
        host(1, 1, 'h24, 0, 32'h77, "R5");
        rd_sts("R5");
        host(1, 1, 'h18, 2, 32'h20, "R6");
        be_finish(0, "R7");
        rd_sts("R9");
        host(1, 1, 'h18, 2, 32'h40, "R11");
        rd_sts("R14");
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule